// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block turns a 32-bit virtual address into a 32-bit physical address with a small four-way, sixteen-set translation buffer that holds 4 KB pages. The virtual address is cut into three fields: a tag, a set number and an in-page offset. The tag is then compared in parallel with every way of the selected set. When a valid way matches, the stored frame number is joined to the offset to form the physical address. The block also extracts the tag and index fields that a 2-way, 128-set, 32-byte-line data cache would take from that physical address.

A miss handler outside the block installs translations through a one-cycle fill port. A flush input invalidates the whole buffer at once. The lookup is combinational from the current contents, and the response is registered at the next rising clock edge. The table walk and the cache itself are not part of the block.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual address is split as tag = bits 31:16, set = bits 15:12, offset = bits 11:0. A way matches only when its set number and its stored tag both equal those of the address.
- R2: When `lookup_en` is high at a rising edge, `rsp_valid` is high after that edge. `rsp_hit` is high after that edge exactly when some valid way of the addressed set holds the address tag.
- R3: On a hit, `rsp_paddr` equals {stored 20-bit frame, virtual bits 11:0}.
- R4: On a miss, `rsp_hit`, `rsp_paddr`, `rsp_ctag` and `rsp_cidx` are all zero.
- R5: On a hit, `rsp_ctag` equals `rsp_paddr` bits 31:12 and `rsp_cidx` equals `rsp_paddr` bits 11:5.
- R6: A fill writes tag and frame into entry (`fill_way`, `fill_set`) and marks it valid at one edge. A lookup at that same edge still sees the old contents. Lookups at later edges see the new entry.
- R7: A flush invalidates every entry at one edge. A fill at the same edge is dropped.
- R8: When more than one valid way of a set matches, the way with the lowest number supplies the frame.
- R9: While `rst_n` is low, every entry is invalid and all response outputs are zero.
- R10: When `lookup_en` is low at an edge, all response outputs are zero after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lookup_en | input | 1 | Translate `vaddr` at this edge |
| vaddr | input | 32 | Virtual address |
| fill_en | input | 1 | Install an entry at this edge |
| fill_way | input | 2 | Way to write |
| fill_set | input | 4 | Set to write |
| fill_tag | input | 16 | Tag to store |
| fill_frame | input | 20 | Physical frame number to store |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | A lookup was made at the last edge |
| rsp_hit | output | 1 | That lookup hit |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_ctag | output | 20 | Cache tag of the physical address |
| rsp_cidx | output | 7 | Cache set index of the physical address |

## Verification
The bench builds the block with its default geometry: 4 ways, 16 sets, 12 offset bits and a 7-bit cache index. At that size the bench can fill all 64 entries with distinct tags and frames and read each one back, so every way and set pairing is checked. The small way count also lets the bench put two identical tags into one set to check that the lower way wins. Same-edge cases are covered as well: a fill against a lookup, a flush against a fill, and a reset in mid-run.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int DEF_VA_W       = 32;
    localparam int DEF_PAGE_BITS  = 12;
    localparam int DEF_SET_BITS   = 4;
    localparam int DEF_WAYS       = 4;
    localparam int DEF_FRM_W      = 20;
    localparam int DEF_CLINE_BITS = 5;
    localparam int DEF_CSET_BITS  = 7;
endpackage

// File: rtl/tlb_fields.sv
// Splits a virtual address into lookup fields and a physical address into cache fields.
module tlb_fields #(
    parameter int VA_W       = 32,
    parameter int PAGE_BITS  = 12,
    parameter int SET_BITS   = 4,
    parameter int PA_W       = 32,
    parameter int CLINE_BITS = 5,
    parameter int CSET_BITS  = 7
) (
    input  logic [VA_W-1:0]                     va,
    input  logic [PA_W-1:CLINE_BITS]            pa_hi,
    output logic [VA_W-PAGE_BITS-SET_BITS-1:0]  v_tag,
    output logic [SET_BITS-1:0]                 v_set,
    output logic [PAGE_BITS-1:0]                v_off,
    output logic [PA_W-CLINE_BITS-CSET_BITS-1:0] c_tag,
    output logic [CSET_BITS-1:0]                c_idx
);
    localparam int CIDX_LO = CLINE_BITS;
    localparam int CTAG_LO = CLINE_BITS + CSET_BITS;

    // R1: field boundaries
    assign v_off = va[PAGE_BITS-1:0];
    assign v_set = va[PAGE_BITS+SET_BITS-1:PAGE_BITS];
    assign v_tag = va[VA_W-1:PAGE_BITS+SET_BITS];
    // R5: cache fields
    assign c_idx = pa_hi[CTAG_LO-1:CIDX_LO];
    assign c_tag = pa_hi[PA_W-1:CTAG_LO];
endmodule

// File: rtl/tlb_store.sv
// Entry storage: valid bits with reset, tag and frame arrays, one write port.
module tlb_store #(
    parameter int WAYS     = 4,
    parameter int SET_BITS = 4,
    parameter int TAG_W    = 16,
    parameter int FRM_W    = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          fill_en,
    input  logic [$clog2(WAYS)-1:0]       fill_way,
    input  logic [SET_BITS-1:0]           fill_set,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [FRM_W-1:0]              fill_frame,
    input  logic [SET_BITS-1:0]           rd_set,
    output logic [WAYS-1:0]               rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0]    rd_tag,
    output logic [WAYS-1:0][FRM_W-1:0]    rd_frame
);
    localparam int SETS = 1 << SET_BITS;

    logic [WAYS-1:0][SETS-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]          tag_d   [WAYS][SETS];
    logic [TAG_W-1:0]          tag_q   [WAYS][SETS];
    logic [FRM_W-1:0]          frame_d [WAYS][SETS];
    logic [FRM_W-1:0]          frame_q [WAYS][SETS];

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        frame_d = frame_q;
        if (flush) begin
            // R7: flush clears everything and drops a simultaneous fill
            valid_d = '0;
        end else if (fill_en) begin
            // R6: one-edge install
            valid_d[fill_way][fill_set] = 1'b1;
            tag_d[fill_way][fill_set]   = fill_tag;
            frame_d[fill_way][fill_set] = fill_frame;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        tag_q   <= tag_d;
        frame_q <= frame_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = valid_q[w][rd_set];
        assign rd_tag[w]   = tag_q[w][rd_set];
        assign rd_frame[w] = frame_q[w][rd_set];
    end
endmodule

// File: rtl/tlb_match.sv
// Parallel tag compare across the ways of one set, lowest way wins.
module tlb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    parameter int FRM_W = 20
) (
    input  logic [TAG_W-1:0]            look_tag,
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [WAYS-1:0][FRM_W-1:0]  way_frame,
    output logic                        hit,
    output logic [FRM_W-1:0]            frame
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    // R8: scan from the top so the lowest matching way is written last
    always_comb begin
        hit   = 1'b0;
        frame = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) begin
                hit   = 1'b1;
                frame = way_frame[w];
            end
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W       = DEF_VA_W,
    parameter int PAGE_BITS  = DEF_PAGE_BITS,
    parameter int SET_BITS   = DEF_SET_BITS,
    parameter int WAYS       = DEF_WAYS,
    parameter int FRM_W      = DEF_FRM_W,
    parameter int CLINE_BITS = DEF_CLINE_BITS,
    parameter int CSET_BITS  = DEF_CSET_BITS
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          lookup_en,
    input  logic [VA_W-1:0]                               vaddr,
    input  logic                                          fill_en,
    input  logic [$clog2(WAYS)-1:0]                       fill_way,
    input  logic [SET_BITS-1:0]                           fill_set,
    input  logic [VA_W-PAGE_BITS-SET_BITS-1:0]            fill_tag,
    input  logic [FRM_W-1:0]                              fill_frame,
    input  logic                                          flush,
    output logic                                          rsp_valid,
    output logic                                          rsp_hit,
    output logic [FRM_W+PAGE_BITS-1:0]                    rsp_paddr,
    output logic [FRM_W+PAGE_BITS-CLINE_BITS-CSET_BITS-1:0] rsp_ctag,
    output logic [CSET_BITS-1:0]                          rsp_cidx
);
    localparam int TAG_W  = VA_W - PAGE_BITS - SET_BITS;
    localparam int PA_W   = FRM_W + PAGE_BITS;
    localparam int CTAG_W = PA_W - CLINE_BITS - CSET_BITS;

    typedef struct packed {
        logic                  valid;
        logic                  hit;
        logic [PA_W-1:0]       paddr;
        logic [CTAG_W-1:0]     ctag;
        logic [CSET_BITS-1:0]  cidx;
    } rsp_t;

    logic [TAG_W-1:0]            v_tag;
    logic [SET_BITS-1:0]         v_set;
    logic [PAGE_BITS-1:0]        v_off;
    logic [WAYS-1:0]             rd_valid;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [WAYS-1:0][FRM_W-1:0]  rd_frame;
    logic                        m_hit;
    logic [FRM_W-1:0]            m_frame;
    logic [PA_W-1:0]             pa_cand;
    logic [CTAG_W-1:0]           c_tag;
    logic [CSET_BITS-1:0]        c_idx;
    rsp_t                        rsp_d, rsp_q;

    assign pa_cand = {m_frame, v_off};

    tlb_fields #(
        .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .SET_BITS(SET_BITS),
        .PA_W(PA_W), .CLINE_BITS(CLINE_BITS), .CSET_BITS(CSET_BITS)
    ) u_fields (
        .va    (vaddr),
        .pa_hi (pa_cand[PA_W-1:CLINE_BITS]),
        .v_tag (v_tag),
        .v_set (v_set),
        .v_off (v_off),
        .c_tag (c_tag),
        .c_idx (c_idx)
    );

    tlb_store #(
        .WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_W(TAG_W), .FRM_W(FRM_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_en    (fill_en),
        .fill_way   (fill_way),
        .fill_set   (fill_set),
        .fill_tag   (fill_tag),
        .fill_frame (fill_frame),
        .rd_set     (v_set),
        .rd_valid   (rd_valid),
        .rd_tag     (rd_tag),
        .rd_frame   (rd_frame)
    );

    tlb_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .FRM_W(FRM_W)
    ) u_match (
        .look_tag  (v_tag),
        .way_valid (rd_valid),
        .way_tag   (rd_tag),
        .way_frame (rd_frame),
        .hit       (m_hit),
        .frame     (m_frame)
    );

    // R2, R3, R4, R5, R10: response formed from current contents
    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lookup_en;
        if (lookup_en && m_hit) begin
            rsp_d.hit   = 1'b1;
            rsp_d.paddr = pa_cand;
            rsp_d.ctag  = c_tag;
            rsp_d.cidx  = c_idx;
        end
    end

    // R9: asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_paddr = rsp_q.paddr;
    assign rsp_ctag  = rsp_q.ctag;
    assign rsp_cidx  = rsp_q.cidx;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int PAGE_BITS = 12,
    parameter int PA_W      = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 lookup_en,
    input logic [PAGE_BITS-1:0] voff,
    input logic                 flush,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [PA_W-1:0]      rsp_paddr
);
    // R10
    valid_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(lookup_en)));

    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_en |=> (!rsp_hit || (rsp_paddr[PAGE_BITS-1:0] == $past(voff))));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0));

    // R7
    flush_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush ##1 lookup_en |=> !rsp_hit);
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .PAGE_BITS(PAGE_BITS), .PA_W(FRM_W + PAGE_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookup_en (lookup_en),
    .voff      (vaddr[PAGE_BITS-1:0]),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lookup_en = 1'b0;
    logic [31:0] vaddr = '0;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_way = '0;
    logic [3:0]  fill_set = '0;
    logic [15:0] fill_tag = '0;
    logic [19:0] fill_frame = '0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr;
    logic [19:0] rsp_ctag;
    logic [6:0]  rsp_cidx;

    tlb_xlate u0 (
        .clk(clk), .rst_n(rst_n), .lookup_en(lookup_en), .vaddr(vaddr),
        .fill_en(fill_en), .fill_way(fill_way), .fill_set(fill_set),
        .fill_tag(fill_tag), .fill_frame(fill_frame), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_ctag(rsp_ctag), .rsp_cidx(rsp_cidx)
    );

    always #2 clk = ~clk;

    // behavioural model
    bit          m_v   [4][16];
    bit   [15:0] m_tag [4][16];
    bit   [19:0] m_frm [4][16];

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          have_exp = 0;
    bit          e_valid, e_hit;
    bit   [31:0] e_paddr;
    bit   [19:0] e_ctag;
    bit   [6:0]  e_cidx;
    string       e_req;
    bit          finished = 0;

    task automatic compare();
        n_cmp++;
        if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_paddr !== e_paddr ||
            rsp_ctag !== e_ctag || rsp_cidx !== e_cidx) begin
            n_bad++;
            $display("FAIL %s: got v=%0b h=%0b pa=%h ct=%h ci=%h exp v=%0b h=%0b pa=%h ct=%h ci=%h",
                     e_req, rsp_valid, rsp_hit, rsp_paddr, rsp_ctag, rsp_cidx,
                     e_valid, e_hit, e_paddr, e_ctag, e_cidx);
        end
    endtask

    // one cycle: check last result, drive inputs, predict, update model
    task automatic step(input bit rst, input bit lk, input bit [31:0] va,
                        input bit fl, input bit fe, input bit [1:0] fw,
                        input bit [3:0] fs, input bit [15:0] ft, input bit [19:0] ff,
                        input string req);
        @(negedge clk);
        if (have_exp) compare();
        rst_n = !rst; lookup_en = lk; vaddr = va; flush = fl;
        fill_en = fe; fill_way = fw; fill_set = fs; fill_tag = ft; fill_frame = ff;
        e_valid = 0; e_hit = 0; e_paddr = '0; e_ctag = '0; e_cidx = '0; e_req = req;
        if (!rst && lk) begin
            e_valid = 1;
            for (int w = 0; w < 4; w++) begin
                if (!e_hit && m_v[w][va[15:12]] && m_tag[w][va[15:12]] == va[31:16]) begin
                    e_hit   = 1;
                    e_paddr = {m_frm[w][va[15:12]], va[11:0]};
                    e_ctag  = e_paddr[31:12];
                    e_cidx  = e_paddr[11:5];
                end
            end
        end
        if (rst || fl) begin
            for (int w = 0; w < 4; w++)
                for (int s = 0; s < 16; s++) m_v[w][s] = 0;
        end else if (fe) begin
            m_v[fw][fs] = 1; m_tag[fw][fs] = ft; m_frm[fw][fs] = ff;
        end
        have_exp = 1;
    endtask

    task automatic look(input bit [31:0] va, input string req);
        step(0, 1, va, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic put(input bit [1:0] w, input bit [3:0] s, input bit [15:0] t,
                       input bit [19:0] f, input string req);
        step(0, 0, 0, 0, 1, w, s, t, f, req);
    endtask

    initial begin
        // R9: reset state
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 1, 32'h1234_3ABC, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 1, 32'h1234_3ABC, 0, 0, 0, 0, 0, 0, "R9");
        // R4: empty buffer misses
        look(32'h0000_0000, "R4");
        look(32'hFFFF_FFFF, "R4");
        // R6: lookup at the fill edge sees old contents
        step(0, 1, 32'h1234_3ABC, 0, 1, 0, 3, 16'h1234, 20'hABCDE, "R6");
        // R2 R3 R5: hit next cycle
        look(32'h1234_3ABC, "R3");
        look(32'h1234_3FE0, "R5");
        // R1: same tag other set, other tag same set
        look(32'h1234_4ABC, "R1");
        look(32'h1235_3ABC, "R1");
        // R1 R2: every way and set
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++)
                put(w[1:0], s[3:0], 16'h4000 + 16'(w * 16 + s), 20'h10000 + 20'(w * 256 + s * 7), "R6");
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++)
                look({16'h4000 + 16'(w * 16 + s), s[3:0], 12'(s * 151 + w * 37)}, "R2");
        // R8: duplicate tag in ways 2 and 1 of set 5
        put(2, 5, 16'hBEEF, 20'h22222, "R8");
        put(1, 5, 16'hBEEF, 20'h11111, "R8");
        look(32'hBEEF_5123, "R8");
        // R10: disabled lookup of a present address
        step(0, 0, 32'hBEEF_5123, 0, 0, 0, 0, 0, 0, "R10");
        look(32'hBEEF_5FFF, "R8");
        // R7: flush with simultaneous fill
        step(0, 0, 0, 1, 1, 0, 9, 16'h7777, 20'h77777, "R7");
        look(32'hBEEF_5123, "R7");
        look(32'h7777_9000, "R7");
        look(32'h4000_0000, "R7");
        // refill then reset in mid-run
        put(3, 15, 16'hCAFE, 20'hFEDCB, "R6");
        look(32'hCAFE_F01F, "R5");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
        look(32'hCAFE_F01F, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
        @(negedge clk);
        compare();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule